// File: doc/BRIEF.md
# Multi-Channel DMA Request Arbiter

This block decides which of sixteen DMA channels the transfer engine serves next. Each channel watches one of thirty-two hardware trigger lines, chosen by a per-channel select field, or takes a software request strobe. A request that arrives is kept in a per-channel active flag. How long it is kept depends on the channel's trigger span: one buffer, one block, a run of repeated blocks, or the whole linked chain. The engine moves data one buffer at a time. It tells the arbiter when a buffer ends and how far that ending reached, so a long request is arbitrated again at every buffer boundary. A higher-priority channel therefore never waits longer than one buffer.

The arbiter holds a single grant, made of a valid bit and a channel number, from the start of a buffer until the engine reports it done. It then drops the grant for one cycle and arbitrates again. When a hardware-triggered request is served for the first time, the arbiter returns a one-cycle acknowledge on the trigger line it came from, so the requesting source can withdraw. All pins are plain control and status levels or pulses. No data flows through the block, so there is no valid/ready pairing and no back-pressure. The engine must simply honour the grant.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `gnt_vld` is 0, `trig_ack` is all zeros and `req_active` is all zeros.
- R2: A channel with `ch_sw_mode` low takes its hardware trigger from `trig_in[s]`, where `s` is its 6-bit field `ch_trig_sel[6c+5:6c]`. A select value of 32 or more picks no trigger. The acknowledge for that channel goes out on `trig_ack[s]`.
- R3: A channel with `ch_sw_mode` high ignores `trig_in` completely. A pulse on `sw_req[c]` sets `req_active[c]` for an enabled channel in either mode. A request set by software never raises `trig_ack`.
- R4: While `gnt_vld` is 0 and any enabled channel has `req_active` set, a grant appears on the next clock. `gnt_ch` stays stable until `buf_done` is sampled high. The clock after that, `gnt_vld` is 0, and arbitration resumes on the clock that follows.
- R5: The grant goes to the requesting enabled channel with the highest `ch_prio` level (3 is highest, 0 lowest). Among equal levels, the lowest channel index wins.
- R6: `ch_prio` for a channel is captured only while its `ch_en` is low. Changes made while the channel is enabled have no effect until the channel is disabled again.
- R7: `ch_trig_mode` encodes the request span: 0 = one buffer, 1 = one block, 2 = repeated block run, 3 = whole chain. In span 0, a hardware request ends with its buffer, and that channel's trigger is not latched again until `wr_done` is pulsed with `wr_done_ch` equal to that channel. Other channels are granted in the meantime.
- R8: `done_lvl` with `buf_done` reports how far the finished buffer reached: 0 = buffer only, 1 = block end, 2 = repeat run end, 3 = chain end. A granted channel's request stays active until `done_lvl` is at least its span code.
- R9: `trig_ack` is a single-cycle pulse. It is high in the first cycle of the grant that serves the first buffer of a hardware request, and in no other cycle.
- R10: Channels in hardware mode that select the same trigger all latch a request from it. Only the lowest-index enabled hardware-mode channel with that select raises the acknowledge.
- R11: `req_active[c]` clears when the channel is disabled, when a granted buffer ends with `buf_err`, or when it ends at chain level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 32 | Hardware trigger request levels |
| ch_en | input | 16 | Per-channel enable |
| ch_sw_mode | input | 16 | Per-channel software-only mode |
| sw_req | input | 16 | Per-channel software request pulse |
| ch_trig_mode | input | 32 | Per-channel 2-bit request span code |
| ch_trig_sel | input | 96 | Per-channel 6-bit trigger select |
| ch_prio | input | 32 | Per-channel 2-bit priority level |
| buf_done | input | 1 | Engine finished the granted buffer |
| buf_err | input | 1 | The finished buffer ended in error |
| done_lvl | input | 2 | Completion level reached with buf_done |
| wr_done | input | 1 | Write phase finished for a channel |
| wr_done_ch | input | 4 | Channel whose write phase finished |
| gnt_vld | output | 1 | A grant is held |
| gnt_ch | output | 4 | Granted channel |
| trig_ack | output | 32 | One-cycle acknowledge per trigger line |
| req_active | output | 16 | Per-channel latched request flag |

## Verification
The bench goes after the buffer-span hold. A design that forgets the write-phase blocking relatches a trigger that is still high straight away and serves the same channel twice, starving the lower-priority channel that should slip in. It checks that a block-span request survives a buffer-level completion and is granted again with no second acknowledge. An arbiter that clears early would lose the rest of the block, and one that acknowledges every grant would pulse twice. Shared triggers are driven so that the higher-priority channel is the one that must stay silent. Priority is changed while a channel is enabled, which shows whether a design that samples it live picks the wrong winner.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // how far a finished buffer reached; also used as the request span code
  typedef enum logic [1:0] {
    SPAN_BUFFER = 2'd0,
    SPAN_BLOCK  = 2'd1,
    SPAN_REPEAT = 2'd2,
    SPAN_CHAIN  = 2'd3
  } span_e;

  localparam int PRIO_W = 2;
  localparam int SPAN_W = 2;

  function automatic logic span_covers(logic [SPAN_W-1:0] reached,
                                       logic [SPAN_W-1:0] wanted);
    return reached >= wanted;
  endfunction

endpackage

// File: rtl/dma_arb_trig.sv
module dma_arb_trig #(
  parameter int NUM_CH   = 16,
  parameter int NUM_TRIG = 32,
  parameter int SEL_W    = 6
) (
  input  logic [NUM_TRIG-1:0]        trig_in,
  input  logic [NUM_CH*SEL_W-1:0]    sel_flat,
  input  logic [NUM_CH-1:0]          en,
  input  logic [NUM_CH-1:0]          sw_mode,
  output logic [NUM_CH-1:0]          hw_hit,
  output logic [NUM_CH-1:0]          ack_owner,
  output logic [NUM_CH*NUM_TRIG-1:0] dec_flat
);

  // one-hot decode of each channel's select; out-of-range selects give zero
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_tr
      assign dec_flat[c*NUM_TRIG+t] = (sel_flat[c*SEL_W +: SEL_W] == SEL_W'(t));
    end
    assign hw_hit[c] = |(trig_in & dec_flat[c*NUM_TRIG +: NUM_TRIG]);
  end

  // the lowest-index hardware listener of a trigger owns its acknowledge
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      ack_owner[c] = en[c] && !sw_mode[c];
      for (int j = 0; j < c; j++) begin
        if (en[j] && !sw_mode[j] &&
            sel_flat[j*SEL_W +: SEL_W] == sel_flat[c*SEL_W +: SEL_W])
          ack_owner[c] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/dma_arb_chan.sv
module dma_arb_chan
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sw_mode,
  input  logic [SPAN_W-1:0] span,
  input  logic [PRIO_W-1:0] prio_in,
  input  logic              hw_hit,
  input  logic              sw_req,
  input  logic              done_hit,
  input  logic              done_err,
  input  logic [SPAN_W-1:0] done_lvl,
  input  logic              wr_hit,
  input  logic              start_hit,
  output logic              pend,
  output logic              hw_src,
  output logic              acked,
  output logic [PRIO_W-1:0] prio_q
);

  logic wr_hold;
  logic finish;
  logic take;

  assign finish = done_hit && (done_err || span_covers(done_lvl, span));
  assign take   = !pend && (sw_req || (hw_hit && !sw_mode && !wr_hold));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q  <= '0;
      pend    <= 1'b0;
      hw_src  <= 1'b0;
      acked   <= 1'b0;
      wr_hold <= 1'b0;
    end else begin
      if (!en) prio_q <= prio_in;

      if (!en) begin
        pend   <= 1'b0;
        hw_src <= 1'b0;
        acked  <= 1'b0;
      end else if (finish) begin
        pend   <= 1'b0;
        hw_src <= 1'b0;
        acked  <= 1'b0;
      end else if (take) begin
        pend   <= 1'b1;
        hw_src <= !sw_req;
        acked  <= 1'b0;
      end else if (start_hit) begin
        acked  <= 1'b1;
      end

      if (finish && hw_src) wr_hold <= 1'b1;
      else if (wr_hit)      wr_hold <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int NUM_CH = 16,
  parameter int PRIO_W = 2,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]        elig,
  input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
  output logic                     any,
  output logic [CH_W-1:0]          win
);

  logic [PRIO_W-1:0] best;

  // strict compare keeps the lowest index on equal levels
  always_comb begin
    any  = 1'b0;
    win  = '0;
    best = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (elig[c] && (!any || prio_flat[c*PRIO_W +: PRIO_W] > best)) begin
        any  = 1'b1;
        win  = CH_W'(c);
        best = prio_flat[c*PRIO_W +: PRIO_W];
      end
    end
  end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int NUM_TRIG = 32,
  parameter int SEL_W    = 6,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_TRIG-1:0]      trig_in,
  input  logic [NUM_CH-1:0]        ch_en,
  input  logic [NUM_CH-1:0]        ch_sw_mode,
  input  logic [NUM_CH-1:0]        sw_req,
  input  logic [NUM_CH*SPAN_W-1:0] ch_trig_mode,
  input  logic [NUM_CH*SEL_W-1:0]  ch_trig_sel,
  input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
  input  logic                     buf_done,
  input  logic                     buf_err,
  input  logic [SPAN_W-1:0]        done_lvl,
  input  logic                     wr_done,
  input  logic [CH_W-1:0]          wr_done_ch,
  output logic                     gnt_vld,
  output logic [CH_W-1:0]          gnt_ch,
  output logic [NUM_TRIG-1:0]      trig_ack,
  output logic [NUM_CH-1:0]        req_active
);

  logic [NUM_CH-1:0]          hw_hit, ack_owner;
  logic [NUM_CH*NUM_TRIG-1:0] dec_flat;
  logic [NUM_CH-1:0]          pend, hw_src, acked;
  logic [NUM_CH*PRIO_W-1:0]   prio_eff;
  logic [NUM_CH-1:0]          done_hit, wr_hit, start_hit;
  logic                       any;
  logic [CH_W-1:0]            win;
  logic                       start;
  logic                       ack_ok;
  logic [NUM_TRIG-1:0]        ack_vec;

  dma_arb_trig #(.NUM_CH(NUM_CH), .NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) u_trig (
    .trig_in   (trig_in),
    .sel_flat  (ch_trig_sel),
    .en        (ch_en),
    .sw_mode   (ch_sw_mode),
    .hw_hit    (hw_hit),
    .ack_owner (ack_owner),
    .dec_flat  (dec_flat)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign done_hit[c]  = buf_done && gnt_vld && (gnt_ch == CH_W'(c));
    assign wr_hit[c]    = wr_done && (wr_done_ch == CH_W'(c));
    assign start_hit[c] = start && (win == CH_W'(c));

    dma_arb_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ch_en[c]),
      .sw_mode   (ch_sw_mode[c]),
      .span      (ch_trig_mode[c*SPAN_W +: SPAN_W]),
      .prio_in   (ch_prio[c*PRIO_W +: PRIO_W]),
      .hw_hit    (hw_hit[c]),
      .sw_req    (sw_req[c]),
      .done_hit  (done_hit[c]),
      .done_err  (buf_err),
      .done_lvl  (done_lvl),
      .wr_hit    (wr_hit[c]),
      .start_hit (start_hit[c]),
      .pend      (pend[c]),
      .hw_src    (hw_src[c]),
      .acked     (acked[c]),
      .prio_q    (prio_eff[c*PRIO_W +: PRIO_W])
    );
  end

  dma_arb_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_pick (
    .elig      (pend & ch_en),
    .prio_flat (prio_eff),
    .any       (any),
    .win       (win)
  );

  assign start   = !gnt_vld && any;
  assign ack_ok  = hw_src[win] && !acked[win] && ack_owner[win];
  assign ack_vec = ack_ok ? dec_flat[int'(win)*NUM_TRIG +: NUM_TRIG] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_vld  <= 1'b0;
      gnt_ch   <= '0;
      trig_ack <= '0;
    end else begin
      trig_ack <= '0;
      if (gnt_vld) begin
        if (buf_done) gnt_vld <= 1'b0;
      end else if (start) begin
        gnt_vld  <= 1'b1;
        gnt_ch   <= win;
        trig_ack <= ack_vec;
      end
    end
  end

  assign req_active = pend;

endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int NUM_CH   = 16,
  parameter int NUM_TRIG = 32,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CH-1:0]   ch_en,
  input logic                buf_done,
  input logic                gnt_vld,
  input logic [CH_W-1:0]     gnt_ch,
  input logic [NUM_TRIG-1:0] trig_ack,
  input logic [NUM_CH-1:0]   req_active
);

  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      live_q <= '0;
    end else begin
      en_q   <= ch_en;
      live_q <= req_active & ch_en;
    end
  end

  p_ack_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig_ack));

  p_ack_new_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_ack) |-> $rose(gnt_vld));

  p_grant_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && !buf_done) |=> (gnt_vld && $stable(gnt_ch)));

  p_grant_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && buf_done) |=> !gnt_vld);

  p_idle_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_vld && |(req_active & ch_en)) |=> gnt_vld);

  p_winner_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_vld) |-> live_q[gnt_ch]);

  p_disabled_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_active & ~en_q) == '0);

endmodule

bind dma_req_arbiter dma_arb_chk #(.NUM_CH(NUM_CH), .NUM_TRIG(NUM_TRIG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ch_en      (ch_en),
  .buf_done   (buf_done),
  .gnt_vld    (gnt_vld),
  .gnt_ch     (gnt_ch),
  .trig_ack   (trig_ack),
  .req_active (req_active)
);

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  typedef struct packed {
    logic [15:0] mask;
    logic [31:0] prio;
    logic [3:0]  win;
  } vec_t;

  // requesters, packed priority levels, expected winner (R5)
  localparam vec_t VECS [8] = '{
    '{16'h0001, 32'h00000000, 4'd0},
    '{16'h8001, 32'hC0000000, 4'd15},
    '{16'h00F0, 32'hAAAAAAAA, 4'd4},
    '{16'hFFFF, 32'h55555555, 4'd0},
    '{16'h0A00, 32'h00440000, 4'd9},
    '{16'h0A00, 32'h00840000, 4'd11},
    '{16'h1234, 32'h00000000, 4'd2},
    '{16'h8000, 32'h00000000, 4'd15}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] trig_in = '0;
  logic [15:0] ch_en = '0;
  logic [15:0] ch_sw_mode = '0;
  logic [15:0] sw_req = '0;
  logic [31:0] ch_trig_mode = '0;
  logic [95:0] ch_trig_sel = '0;
  logic [31:0] ch_prio = '0;
  logic        buf_done = 1'b0;
  logic        buf_err = 1'b0;
  logic [1:0]  done_lvl = '0;
  logic        wr_done = 1'b0;
  logic [3:0]  wr_done_ch = '0;
  logic        gnt_vld;
  logic [3:0]  gnt_ch;
  logic [31:0] trig_ack;
  logic [15:0] req_active;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_arbiter i_dma_req_arbiter (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .ch_en(ch_en),
    .ch_sw_mode(ch_sw_mode), .sw_req(sw_req), .ch_trig_mode(ch_trig_mode),
    .ch_trig_sel(ch_trig_sel), .ch_prio(ch_prio), .buf_done(buf_done),
    .buf_err(buf_err), .done_lvl(done_lvl), .wr_done(wr_done),
    .wr_done_ch(wr_done_ch), .gnt_vld(gnt_vld), .gnt_ch(gnt_ch),
    .trig_ack(trig_ack), .req_active(req_active)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(int c, logic sw, logic [1:0] span, logic [5:0] sel, logic [1:0] p);
    ch_sw_mode[c]          = sw;
    ch_trig_mode[c*2 +: 2] = span;
    ch_trig_sel[c*6 +: 6]  = sel;
    ch_prio[c*2 +: 2]      = p;
  endtask

  task automatic cleanup();
    ch_en = '0; trig_in = '0; sw_req = '0;
    buf_done = 1'b1; buf_err = 1'b0; done_lvl = 2'd3;
    step();
    buf_done = 1'b0; done_lvl = 2'd0;
    step();
    step();
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 gnt_vld", 32'(gnt_vld), 32'h0);
    chk("R1 trig_ack", trig_ack, 32'h0);
    chk("R1 req_active", 32'(req_active), 32'h0);

    // table walk: arbitration winners (R5), software set (R3), chain end (R11)
    for (int k = 0; k < 8; k++) begin
      ch_en = '0; ch_prio = VECS[k].prio; ch_sw_mode = '1; ch_trig_mode = '1;
      step();
      ch_en = VECS[k].mask; sw_req = VECS[k].mask;
      step();
      sw_req = '0;
      step();
      chk($sformatf("R5 vec%0d gnt_vld", k), 32'(gnt_vld), 32'h1);
      chk($sformatf("R5 vec%0d gnt_ch", k), 32'(gnt_ch), 32'(VECS[k].win));
      chk($sformatf("R3 vec%0d req_active", k), 32'(req_active), 32'(VECS[k].mask));
      buf_done = 1'b1; done_lvl = 2'd3;
      step();
      buf_done = 1'b0; ch_en = '0;
      chk($sformatf("R11 vec%0d chain end", k), 32'(req_active[VECS[k].win]), 32'h0);
      step();
      chk($sformatf("R4 vec%0d idle", k), 32'(gnt_vld), 32'h0);
    end
    cleanup();

    // R6 priority frozen while enabled
    ch_prio = '0; ch_trig_mode = '0; ch_sw_mode = '1;
    cfg(0, 1'b1, 2'd0, 6'd0, 2'd0);
    cfg(1, 1'b1, 2'd0, 6'd0, 2'd1);
    step();
    ch_en = 16'h0003;
    step();
    ch_prio[1:0] = 2'd3;
    step();
    sw_req = 16'h0003;
    step();
    sw_req = '0;
    step();
    chk("R6 frozen prio winner", 32'(gnt_ch), 32'd1);
    cleanup();
    step();
    ch_en = 16'h0003; sw_req = 16'h0003;
    step();
    sw_req = '0;
    step();
    chk("R6 new prio after disable", 32'(gnt_ch), 32'd0);
    cleanup();

    // R2 R7 R9 hardware trigger, buffer span, write-phase hold
    ch_prio = '0; ch_sw_mode = '1; ch_trig_mode = '0;
    cfg(2, 1'b0, 2'd0, 6'd5, 2'd3);
    cfg(3, 1'b1, 2'd0, 6'd0, 2'd0);
    step();
    ch_en = 16'h000C; trig_in[5] = 1'b1;
    step();
    chk("R2 hw latch", 32'(req_active), 32'h0004);
    step();
    chk("R2 grant hw channel", 32'(gnt_ch), 32'd2);
    chk("R2 ack on selected line", trig_ack, 32'h0000_0020);
    step();
    chk("R9 ack single cycle", trig_ack, 32'h0);
    chk("R4 grant held", {31'h0, gnt_vld}, 32'h1);
    buf_done = 1'b1; done_lvl = 2'd0;
    step();
    buf_done = 1'b0; sw_req = 16'h0008;
    chk("R7 cleared after buffer", 32'(req_active[2]), 32'h0);
    chk("R4 drop after done", 32'(gnt_vld), 32'h0);
    step();
    sw_req = '0;
    chk("R7 relatch blocked", 32'(req_active), 32'h0008);
    step();
    chk("R7 other channel interleaves", 32'(gnt_ch), 32'd3);
    chk("R3 no ack for software", trig_ack, 32'h0);
    buf_done = 1'b1;
    step();
    buf_done = 1'b0; wr_done = 1'b1; wr_done_ch = 4'd2;
    step();
    wr_done = 1'b0;
    chk("R7 hold until write edge", 32'(req_active), 32'h0);
    step();
    chk("R7 relatch after write done", 32'(req_active), 32'h0004);
    step();
    chk("R9 new request acked", trig_ack, 32'h0000_0020);
    cleanup();

    // R2 out-of-range select
    cfg(5, 1'b0, 2'd0, 6'd40, 2'd0);
    step();
    ch_en = 16'h0020; trig_in = '1;
    step(); step();
    chk("R2 select beyond range", 32'(req_active), 32'h0);
    cleanup();

    // R8 R9 block span keeps request, ack only on first buffer
    cfg(6, 1'b0, 2'd1, 6'd7, 2'd0);
    step();
    ch_en = 16'h0040; trig_in[7] = 1'b1;
    step(); step();
    chk("R9 first buffer ack", trig_ack, 32'h0000_0080);
    trig_in = '0; buf_done = 1'b1; done_lvl = 2'd0;
    step();
    buf_done = 1'b0;
    chk("R8 block span kept", 32'(req_active), 32'h0040);
    step();
    chk("R8 regrant", 32'(gnt_ch), 32'd6);
    chk("R9 no ack on later buffer", trig_ack, 32'h0);
    buf_done = 1'b1; done_lvl = 2'd1;
    step();
    buf_done = 1'b0;
    chk("R8 block end clears", 32'(req_active), 32'h0);
    step();
    chk("R8 no further grant", 32'(gnt_vld), 32'h0);
    cleanup();

    // R8 repeated-block span survives block end
    cfg(7, 1'b1, 2'd2, 6'd0, 2'd0);
    step();
    ch_en = 16'h0080; sw_req = 16'h0080;
    step();
    sw_req = '0;
    step();
    buf_done = 1'b1; done_lvl = 2'd1;
    step();
    buf_done = 1'b0;
    chk("R8 repeat span kept at block end", 32'(req_active), 32'h0080);
    step();
    buf_done = 1'b1; done_lvl = 2'd2;
    step();
    buf_done = 1'b0;
    chk("R8 repeat end clears", 32'(req_active), 32'h0);
    cleanup();

    // R10 shared trigger
    cfg(8, 1'b0, 2'd0, 6'd9, 2'd0);
    cfg(10, 1'b0, 2'd0, 6'd9, 2'd1);
    step();
    ch_en = 16'h0500; trig_in[9] = 1'b1;
    step();
    chk("R10 both latch", 32'(req_active), 32'h0500);
    step();
    chk("R10 higher prio wins", 32'(gnt_ch), 32'd10);
    chk("R10 non-owner silent", trig_ack, 32'h0);
    buf_done = 1'b1; done_lvl = 2'd0;
    step();
    buf_done = 1'b0;
    step();
    chk("R10 owner granted", 32'(gnt_ch), 32'd8);
    chk("R10 owner acks", trig_ack, 32'h0000_0200);
    cleanup();

    // R3 software mode ignores hardware trigger
    cfg(12, 1'b1, 2'd0, 6'd3, 2'd0);
    step();
    ch_en = 16'h1000; trig_in[3] = 1'b1;
    step(); step();
    chk("R3 trigger ignored", 32'(req_active), 32'h0);
    sw_req = 16'h1000;
    step();
    sw_req = '0;
    step();
    chk("R3 software grant", 32'(gnt_ch), 32'd12);
    chk("R3 software no ack", trig_ack, 32'h0);
    cleanup();

    // R11 disable and error clear
    cfg(13, 1'b1, 2'd3, 6'd0, 2'd0);
    cfg(14, 1'b1, 2'd3, 6'd0, 2'd0);
    step();
    ch_en = 16'h6000; sw_req = 16'h6000;
    step();
    sw_req = '0;
    step();
    chk("R11 grant before disable", 32'(gnt_ch), 32'd13);
    ch_en = 16'h2000;
    step();
    chk("R11 disable clears", 32'(req_active), 32'h2000);
    buf_done = 1'b1; buf_err = 1'b1; done_lvl = 2'd0;
    step();
    buf_done = 1'b0; buf_err = 1'b0;
    chk("R11 error clears", 32'(req_active), 32'h0);
    chk("R11 grant dropped", 32'(gnt_vld), 32'h0);
    cleanup();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule